// File: doc/BRIEF.md
# Power-Down and Calibration Sequencer

This block sequences a clock-recovery loop from one shared control line. Held high, the line powers the loop down: the recovered-data and recovered-clock drivers are turned off and the loss-of-lock flag is held low. When the line falls after a long enough high time, the fall is taken as a request to recalibrate. The block then resets the loop logic, starts the calibration engine and waits for it to finish. Last, it enables lock acquisition and returns to normal running once lock is reported.

The control line is brought into the clock domain by a synchronizer. A timer counts how long the synchronized line stays high. A falling edge counts as a calibration request only if the count reached `HOLD_CYC` clock cycles, which is 1 µs at the default clock. Calibration may only start while the reference-clock-valid flag is true. If the flag is false, the block parks in a pending state until the flag rises or the line goes high again. With the line low, as it is when undriven, the block sits in normal running.

Top module: `pdcal_seq`

## Requirements
- R1: From the third rising clock edge after `pwr_cal_i` rises, and for as long as it stays high, `state_o` reads OFF (code 1) and `drv_off_o` is 1.
- R2: `lol_o` is 0 whenever the state is OFF. In every other state it follows `lol_raw_i`.
- R3: A release counts as a request only if `pwr_cal_i` was high for at least `HOLD_CYC` clock cycles. After a shorter high time, the block goes to RUN (code 0) on the third edge after the fall, with no reset and no `cal_start_o` pulse.
- R4: A counted release while `ref_ok_i` is 1 enters RESET (code 2) on the third edge after the fall. RESET lasts exactly `RST_CYC` cycles, during which `loop_rst_o` is 1.
- R5: A counted release while `ref_ok_i` is 0 enters PENDING (code 5). From PENDING the block moves to RESET on the first edge that sees `ref_ok_i` high. A new power-down takes it to OFF instead.
- R6: If `ref_ok_i` is 0 on the edge that ends RESET, the block goes to PENDING instead of CAL. `cal_start_o` is only ever raised when `ref_ok_i` was 1 on the previous edge.
- R7: On entry to CAL (code 3), `cal_start_o` is high for exactly one cycle. CAL holds until an edge sees `cal_done_i` high, and the block then moves to ACQUIRE (code 4).
- R8: `acq_en_o` is 1 in ACQUIRE and RUN. ACQUIRE moves to RUN on the first edge that sees `lol_raw_i` low.
- R9: After reset the block is in RUN, with `drv_off_o`, `loop_rst_o` and `cal_start_o` at 0 and `acq_en_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_cal_i | input | 1 | Shared power-down / calibrate-request line (asynchronous) |
| ref_ok_i | input | 1 | Reference clock is valid |
| cal_done_i | input | 1 | Calibration engine has finished |
| lol_raw_i | input | 1 | Loss-of-lock from the lock detector |
| drv_off_o | output | 1 | Turns off the recovered data and clock drivers |
| lol_o | output | 1 | Masked loss-of-lock flag |
| loop_rst_o | output | 1 | Resets the loop logic |
| cal_start_o | output | 1 | One-cycle pulse that starts calibration |
| acq_en_o | output | 1 | Enables lock acquisition |
| state_o | output | 3 | Sequencer state: 0 RUN, 1 OFF, 2 RESET, 3 CAL, 4 ACQUIRE, 5 PENDING |

## Verification
The assertions assume two things about the inputs. First, `ref_ok_i` and `cal_done_i` are already synchronous to `clk_i`. Second, `pwr_cal_i` reaches the state machine only through the synchronizer, so the power-down property is stated against the synchronized level one edge earlier. The stimulus drives every input on the falling clock edge, so each one is stable at the sampling edge. High times are counted in whole clock cycles, which puts the 1 µs qualification exactly at `HOLD_CYC` and one cycle below it.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_OFF  = 3'd1,
    ST_RST  = 3'd2,
    ST_CAL  = 3'd3,
    ST_ACQ  = 3'd4,
    ST_PEND = 3'd5
  } seq_state_e;
endpackage

// File: rtl/pdcal_sync.sv
module pdcal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[i] <= 1'b0;
          else         sr_q[i] <= d_i;
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[i] <= 1'b0;
          else         sr_q[i] <= sr_q[i-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pdcal_hold_timer.sv
module pdcal_hold_timer #(
  parameter int HOLD_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic qual_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  // saturating high-time counter, cleared while low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!lvl_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == LIMIT);
endmodule

// File: rtl/pdcal_fsm.sv
module pdcal_fsm
  import pdcal_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_i,
  input  logic       qual_i,
  input  logic       ref_ok_i,
  input  logic       cal_done_i,
  input  logic       lol_raw_i,
  output seq_state_e state_o,
  output logic       cal_start_o
);
  localparam int RW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [RW-1:0] RLAST = RW'(RST_CYC - 1);

  seq_state_e state_q, state_d;
  logic [RW-1:0] rcnt_q;
  logic          cal_q;

  always_comb begin
    state_d = state_q;
    if (pd_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = !qual_i ? ST_RUN : (ref_ok_i ? ST_RST : ST_PEND);
        ST_PEND: if (ref_ok_i) state_d = ST_RST;
        ST_RST:  if (rcnt_q == RLAST) state_d = ref_ok_i ? ST_CAL : ST_PEND;
        ST_CAL:  if (cal_done_i) state_d = ST_ACQ;
        ST_ACQ:  if (!lol_raw_i) state_d = ST_RUN;
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      rcnt_q  <= '0;
      cal_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rcnt_q  <= (state_q == ST_RST && state_d == ST_RST) ? rcnt_q + 1'b1 : '0;
      cal_q   <= (state_d == ST_CAL) && (state_q != ST_CAL);
    end
  end

  assign state_o     = state_q;
  assign cal_start_o = cal_q;
endmodule

// File: rtl/pdcal_seq.sv
module pdcal_seq
  import pdcal_pkg::*;
#(
  parameter int HOLD_CYC    = 250,
  parameter int RST_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_cal_i,
  input  logic       ref_ok_i,
  input  logic       cal_done_i,
  input  logic       lol_raw_i,
  output logic       drv_off_o,
  output logic       lol_o,
  output logic       loop_rst_o,
  output logic       cal_start_o,
  output logic       acq_en_o,
  output logic [2:0] state_o
);
  logic       pd_s;
  logic       qual;
  seq_state_e st;

  pdcal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pwr_cal_i), .q_o(pd_s)
  );

  pdcal_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk_i, .rst_ni, .lvl_i(pd_s), .qual_o(qual)
  );

  pdcal_fsm #(.RST_CYC(RST_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .pd_i(pd_s), .qual_i(qual), .ref_ok_i, .cal_done_i, .lol_raw_i,
    .state_o(st), .cal_start_o
  );

  assign state_o    = st;
  assign drv_off_o  = (st == ST_OFF);
  assign loop_rst_o = (st == ST_RST);
  assign acq_en_o   = (st == ST_ACQ) || (st == ST_RUN);
  assign lol_o      = lol_raw_i && (st != ST_OFF);
endmodule

// File: rtl/pdcal_seq_chk.sv
module pdcal_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pd_s,
  input logic       ref_ok_i,
  input logic       drv_off_o,
  input logic       lol_o,
  input logic       cal_start_o,
  input logic [2:0] state_o
);
  localparam logic [2:0] S_PEND = 3'd5;

  p_pd_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pd_s) |-> drv_off_o);

  p_lol_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_off_o |-> !lol_o);

  p_pend_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == S_PEND && !$past(pd_s) && !$past(ref_ok_i)) |-> state_o == S_PEND);

  p_cal_ref_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> $past(ref_ok_i));

  p_cal_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |=> !cal_start_o);
endmodule

bind pdcal_seq pdcal_seq_chk u_chk (
  .clk_i, .rst_ni, .pd_s, .ref_ok_i, .drv_off_o, .lol_o, .cal_start_o, .state_o
);

// File: tb/tb_pdcal_seq.sv
module tb_pdcal_seq;
  localparam int HOLD = 250;
  localparam int RSTC = 4;
  localparam int S_RUN = 0, S_OFF = 1, S_RST = 2, S_CAL = 3, S_ACQ = 4, S_PEND = 5;

  localparam int NV = 6;
  localparam int V_HOLD [NV] = '{300, HOLD, HOLD-1, 20, HOLD, 1};
  localparam int V_REF  [NV] = '{1, 1, 1, 1, 0, 0};
  localparam int V_EXP  [NV] = '{S_RST, S_RST, S_RUN, S_RUN, S_PEND, S_RUN};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pwr_cal_i = 1'b0, ref_ok_i = 1'b0, cal_done_i = 1'b0, lol_raw_i = 1'b0;
  logic drv_off_o, lol_o, loop_rst_o, cal_start_o, acq_en_o;
  logic [2:0] state_o;
  int total = 0, bad = 0;
  bit done = 1'b0;
  int pulses;

  always #2 clk = ~clk;

  pdcal_seq #(.HOLD_CYC(HOLD), .RST_CYC(RSTC)) dut (
    .clk_i(clk), .rst_ni, .pwr_cal_i, .ref_ok_i, .cal_done_i, .lol_raw_i,
    .drv_off_o, .lol_o, .loop_rst_o, .cal_start_o, .acq_en_o, .state_o
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic recover();
    ref_ok_i = 1'b1; cal_done_i = 1'b1; lol_raw_i = 1'b0;
    tick(20);
    chk("R8 recover to run", state_o, S_RUN);
    cal_done_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R9 reset state
    chk("R9 state", state_o, S_RUN);
    chk("R9 drv_off", drv_off_o, 0);
    chk("R9 loop_rst", loop_rst_o, 0);
    chk("R9 cal_start", cal_start_o, 0);
    chk("R9 acq_en", acq_en_o, 1);

    // vector table: high time and ref flag vs state three edges after release
    for (int i = 0; i < NV; i++) begin
      ref_ok_i = V_REF[i] != 0;
      lol_raw_i = 1'b1;
      pwr_cal_i = 1'b1;
      tick(V_HOLD[i]);
      if (V_HOLD[i] >= 3) begin
        chk("R1 off while high", drv_off_o, 1);
        chk("R2 lol masked", lol_o, 0);
      end
      pwr_cal_i = 1'b0;
      tick(3);
      chk("R3/R4/R5 state after release", state_o, V_EXP[i]);
      if (V_EXP[i] == S_RUN) chk("R3 no reset", loop_rst_o, 0);
      if (V_EXP[i] == S_RUN) chk("R2 lol passes", lol_o, 1);
      recover();
    end

    // full sequence timing
    ref_ok_i = 1'b1; lol_raw_i = 1'b1; pulses = 0;
    pwr_cal_i = 1'b1; tick(1);
    chk("R1 not yet off", drv_off_o, 0);
    tick(2);
    chk("R1 off at third edge", drv_off_o, 1);
    tick(HOLD);
    pwr_cal_i = 1'b0;
    tick(3);
    chk("R4 reset entered", loop_rst_o, 1);
    tick(RSTC - 1);
    chk("R4 reset still", state_o, S_RST);
    chk("R7 no pulse yet", cal_start_o, 0);
    tick(1);
    chk("R4 reset length", state_o, S_CAL);
    chk("R7 pulse", cal_start_o, 1);
    tick(1);
    chk("R7 pulse one cycle", cal_start_o, 0);
    tick(5);
    chk("R7 cal waits done", state_o, S_CAL);
    chk("R8 acq off in cal", acq_en_o, 0);
    cal_done_i = 1'b1; tick(1); cal_done_i = 1'b0;
    chk("R7 done to acq", state_o, S_ACQ);
    chk("R8 acq en", acq_en_o, 1);
    tick(2);
    chk("R8 waits lock", state_o, S_ACQ);
    chk("R2 lol in acq", lol_o, 1);
    lol_raw_i = 1'b0; tick(1);
    chk("R8 lock to run", state_o, S_RUN);

    // pending then ref valid
    ref_ok_i = 1'b0;
    pwr_cal_i = 1'b1; tick(HOLD + 2); pwr_cal_i = 1'b0; tick(3);
    chk("R5 pending", state_o, S_PEND);
    tick(10);
    chk("R5 stays pending", state_o, S_PEND);
    ref_ok_i = 1'b1; tick(1);
    chk("R5 ref rise to reset", state_o, S_RST);
    // ref lost at end of reset
    ref_ok_i = 1'b0; tick(RSTC);
    chk("R6 back to pending", state_o, S_PEND);
    chk("R6 no pulse", cal_start_o, 0);
    // pending then power-down reasserted
    pwr_cal_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick(1);
      if (cal_start_o) pulses++;
    end
    chk("R5 pd wins over pending", state_o, S_OFF);
    ref_ok_i = 1'b1; tick(2);
    chk("R5 off holds with ref", state_o, S_OFF);
    chk("R6 no cal while pending/off", pulses, 0);
    pwr_cal_i = 1'b0; tick(3);
    chk("R3 short hold after pend", state_o, S_RUN);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule